// File: doc/BRIEF.md
# Set/Clear Alias Control Register Bank

This block is a bank of 32-bit control words behind a 4 KB word-addressed window. Several control words can be written in two ways. A write to the word's own address ORs the written bits in. A write to the address one word above ANDs the inverse of the written bits in. Software can therefore raise or drop single control bits without first reading the word. Two strap words use the same scheme, with one difference: a protect word two addresses above each strap word stops set-writes to it while that protect word holds any non-zero value. Clear-writes to a strap word are never gated.

The bank also holds plain read/write words, a key word, read-only identity words and three PLL extension words. A read of a PLL extension word always shows bit 31 high. The revision word appears at two addresses, and both take the `rev_in` value during reset. The strap words load from `strap0_in` and `strap1_in` during reset. A write that arrives while the key state is 0 still takes effect, but it raises `lock_err` for one cycle. Reads are combinational from `word_addr`. The port carries a word index, so byte offset = 4 × `word_addr`.

Top module: `alias_regbank`

## Requirements
- R1: During synchronous active-low reset, the words load these values:
  - byte 0x40 = 0xF7C3FED8, 0x50 = 0xFFFFFFFC, 0x80 = 0xFFFF7F8A, 0x90 = 0xFFF0FFF0
  - byte 0x100 = 0x00000040, 0x200 = 0x1000405F
  - bytes 0x04 and 0x14 both = `rev_in`
  - byte 0x500 = `strap0_in`, byte 0x510 = `strap1_in`
  - byte 0x5B0 = CHIP_ID0, byte 0x5B4 = CHIP_ID1
  - every other stored word = 0, and the key state = 0.
- R2: A write to byte 0x40, 0x50, 0x80 or 0x90 ORs `wdata` into that word.
- R3: A write to the alias one word above a set/clear word (byte 0x44, 0x54, 0x84, 0x94) clears every bit of the word below where `wdata` is 1.
- R4: A write to strap byte 0x500 (or 0x510) ORs `wdata` in only when the protect word at byte 0x508 (or 0x518) is zero. Otherwise the strap word is left unchanged.
- R5: A write to strap alias byte 0x504 (or 0x514) clears the `wdata` bits in the strap word whatever the protect word holds.
- R6: A read of byte 0x204, 0x224 or 0x244 returns the stored word with bit 31 forced to 1.
- R7: Writes to bytes 0x04, 0x14, 0x540, 0x5B0 and 0x5B4 leave their read values unchanged. Byte 0x540 reads 0.
- R8: A write to byte 0x00 sets the key state to 1 if `wdata` equals KEY_VALUE and to 0 otherwise. Byte 0x00 reads the key state in bit 0.
- R9: `lock_err` is high for exactly the one cycle after a write to any address other than byte 0x00 that was accepted while the key state was 0. That write is still applied as if the key state were 1.
- R10: Reads of any address not listed in R1–R8 return 0, including the clear aliases. Writes to such addresses change nothing.
- R11: Bytes 0x100, 0x200, 0x204, 0x224, 0x244, 0x508 and 0x518 store the whole written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| word_addr | input | 10 | Word index into the 4 KB window (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `word_addr` |
| rev_in | input | 32 | Revision value loaded during reset |
| strap0_in | input | 32 | First strap word loaded during reset |
| strap1_in | input | 32 | Second strap word loaded during reset |
| lock_err | output | 1 | One-cycle pulse after a write made while the key state is 0 |

## Verification
A register update and a lock-violation pulse can come from the same write. This happens when any non-key address is written while the key state is 0. The bench locks the bank and sweeps writes across the whole window. After each write it checks that `lock_err` pulses and that the stored value still follows the set, clear or plain rule. The second pairing is strap gating against the clear alias. The bench loads protect words with non-zero and zero values before strap writes and strap-alias writes. It compares every readback with a reference model of the bank kept in the bench.

// File: rtl/alias_regbank_pkg.sv
`timescale 1ns/1ps
// Shared widths, word indices and reset constants for the alias register bank.
// Assumes a 4 KB window of 32-bit words addressed by word index.
package alias_regbank_pkg;
    localparam int DATA_W = 32;
    localparam int WIN_BYTES = 4096;
    localparam int IDX_W = $clog2(WIN_BYTES / (DATA_W / 8));

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam idx_t IDX_KEY  = 10'h000;
    localparam idx_t IDX_REVA = 10'h001;
    localparam idx_t IDX_REVB = 10'h005;
    localparam idx_t IDX_RAND = 10'h150;
    localparam idx_t IDX_ID0  = 10'h16C;
    localparam idx_t IDX_ID1  = 10'h16D;

    // Set/clear words; the clear alias lives at index + 1.
    localparam int SC_N = 6;
    localparam idx_t SC_IDX [SC_N] = '{10'h010, 10'h014, 10'h020, 10'h024, 10'h140, 10'h144};
    localparam word_t SC_RST [SC_N] = '{32'hF7C3FED8, 32'hFFFFFFFC, 32'hFFFF7F8A,
                                        32'hFFF0FFF0, 32'h0, 32'h0};
    // Plain word that gates set-writes of each set/clear word, -1 for none.
    localparam int SC_PROT [SC_N] = '{-1, -1, -1, -1, 5, 6};
    // Set/clear words whose reset value comes from a strap input (0 = constant).
    localparam int SC_STRAP [SC_N] = '{0, 0, 0, 0, 1, 2};

    // Plain read/write words.
    localparam int PL_N = 7;
    localparam idx_t PL_IDX [PL_N] = '{10'h040, 10'h080, 10'h081, 10'h089, 10'h091,
                                       10'h142, 10'h146};
    localparam word_t PL_RST [PL_N] = '{32'h00000040, 32'h1000405F, 32'h0, 32'h0, 32'h0,
                                        32'h0, 32'h0};
    // Plain words whose readback carries a forced status bit.
    localparam bit PL_FORCE [PL_N] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
endpackage

// File: rtl/rb_setclr_cell.sv
`timescale 1ns/1ps
// One set/clear control word.
// A set strobe ORs data in unless blocked; a clear strobe removes data bits.
// Assumes at most one of set_en / clr_en is high in a cycle (they decode distinct addresses).
module rb_setclr_cell #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] init_val,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic         block_set,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Purpose: hold the word, applying reset load, clear and gated set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= init_val;
        end else if (clr_en) begin
            q <= q & ~wdata;
        end else if (set_en && !block_set) begin
            q <= q | wdata;
        end
    end
endmodule

// File: rtl/rb_decode.sv
`timescale 1ns/1ps
// Write decoder: turns a write strobe and word index into per-word enables.
// Assumes indices in the package tables are unique and alias slots are unused elsewhere.
module rb_decode
    import alias_regbank_pkg::*;
(
    input  logic      wr_en,
    input  idx_t      word_addr,
    output logic      key_we,
    output logic [SC_N-1:0] sc_set,
    output logic [SC_N-1:0] sc_clr,
    output logic [PL_N-1:0] pl_we
);
    // Purpose: key word write enable.
    assign key_we = wr_en && (word_addr == IDX_KEY);

    for (genvar i = 0; i < SC_N; i++) begin : g_sc
        assign sc_set[i] = wr_en && (word_addr == SC_IDX[i]);
        assign sc_clr[i] = wr_en && (word_addr == idx_t'(SC_IDX[i] + 1'b1));
    end

    for (genvar j = 0; j < PL_N; j++) begin : g_pl
        assign pl_we[j] = wr_en && (word_addr == PL_IDX[j]);
    end
endmodule

// File: rtl/rb_readmux.sv
`timescale 1ns/1ps
// Read multiplexer: selects the addressed word, forces the status bit on PLL
// extension words and returns zero for every unimplemented or alias index.
module rb_readmux
    import alias_regbank_pkg::*;
#(
    parameter int    FORCE_BIT = 31,
    parameter word_t ID0 = 32'h1234ABCD,
    parameter word_t ID1 = 32'h88884444
) (
    input  idx_t  word_addr,
    input  logic  key_q,
    input  word_t rev_q,
    input  word_t sc_q [SC_N],
    input  word_t pl_q [PL_N],
    output word_t rdata
);
    localparam word_t FORCE_MASK = word_t'(1) << FORCE_BIT;

    // Purpose: priority-free select of the one matching word.
    always_comb begin
        rdata = '0;
        if (word_addr == IDX_KEY) rdata = word_t'(key_q);
        if (word_addr == IDX_REVA || word_addr == IDX_REVB) rdata = rev_q;
        if (word_addr == IDX_ID0) rdata = ID0;
        if (word_addr == IDX_ID1) rdata = ID1;
        for (int i = 0; i < SC_N; i++) begin
            if (word_addr == SC_IDX[i]) rdata = sc_q[i];
        end
        for (int j = 0; j < PL_N; j++) begin
            if (word_addr == PL_IDX[j]) rdata = PL_FORCE[j] ? (pl_q[j] | FORCE_MASK) : pl_q[j];
        end
    end
endmodule

// File: rtl/alias_regbank.sv
`timescale 1ns/1ps
// Top of the set/clear alias register bank.
// Holds set/clear words, plain words, the key state and the revision copy;
// flags writes made while locked without blocking them.
// Assumes a single write port and synchronous active-low reset.
module alias_regbank
    import alias_regbank_pkg::*;
#(
    parameter word_t KEY_VALUE = 32'hA5C3_0F1E,
    parameter word_t CHIP_ID0  = 32'h1234ABCD,
    parameter word_t CHIP_ID1  = 32'h88884444,
    parameter int    LOCK_BIT  = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [9:0]  word_addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [31:0] rev_in,
    input  logic [31:0] strap0_in,
    input  logic [31:0] strap1_in,
    output logic        lock_err
);
    logic            key_q;
    word_t           rev_q;
    word_t           sc_q   [SC_N];
    word_t           pl_q   [PL_N];
    word_t           sc_init[SC_N];
    logic [SC_N-1:0] sc_set;
    logic [SC_N-1:0] sc_clr;
    logic [PL_N-1:0] pl_we;
    logic            key_we;

    rb_decode u_dec (
        .wr_en     (wr_en),
        .word_addr (word_addr),
        .key_we    (key_we),
        .sc_set    (sc_set),
        .sc_clr    (sc_clr),
        .pl_we     (pl_we)
    );

    for (genvar i = 0; i < SC_N; i++) begin : g_sc
        logic blk;
        // Purpose: pick the reset source (constant or strap input).
        if (SC_STRAP[i] == 1) begin : g_s0
            assign sc_init[i] = strap0_in;
        end else if (SC_STRAP[i] == 2) begin : g_s1
            assign sc_init[i] = strap1_in;
        end else begin : g_k
            assign sc_init[i] = SC_RST[i];
        end
        // Purpose: gate set-writes by the associated protect word, if any.
        if (SC_PROT[i] >= 0) begin : g_p
            assign blk = |pl_q[SC_PROT[i]];
        end else begin : g_np
            assign blk = 1'b0;
        end
        rb_setclr_cell #(.W(DATA_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_val  (sc_init[i]),
            .set_en    (sc_set[i]),
            .clr_en    (sc_clr[i]),
            .block_set (blk),
            .wdata     (wdata),
            .q         (sc_q[i])
        );
    end

    for (genvar j = 0; j < PL_N; j++) begin : g_pl
        // Purpose: plain word, loaded whole on write.
        always_ff @(posedge clk) begin
            if (!rst_n)      pl_q[j] <= PL_RST[j];
            else if (pl_we[j]) pl_q[j] <= wdata;
        end
    end

    // Purpose: key state follows the last key write comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= 1'b0;
        else if (key_we) key_q <= (wdata == KEY_VALUE);
    end

    // Purpose: single revision copy captured during reset, shown at two indices.
    always_ff @(posedge clk) begin
        if (!rst_n) rev_q <= rev_in;
    end

    // Purpose: one-cycle flag for a non-key write made while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_err <= 1'b0;
        else        lock_err <= wr_en && (word_addr != IDX_KEY) && !key_q;
    end

    rb_readmux #(.FORCE_BIT(LOCK_BIT), .ID0(CHIP_ID0), .ID1(CHIP_ID1)) u_rd (
        .word_addr (word_addr),
        .key_q     (key_q),
        .rev_q     (rev_q),
        .sc_q      (sc_q),
        .pl_q      (pl_q),
        .rdata     (rdata)
    );
endmodule

// File: rtl/alias_regbank_chk.sv
`timescale 1ns/1ps
// Property checker for alias_regbank, attached by bind below.
// Observes ports plus the key state, one set/clear word, one strap word and its protect word.
module alias_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [9:0]  word_addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        lock_err,
    input logic        key_q,
    input logic [31:0] sc0,
    input logic [31:0] strap0,
    input logic [31:0] prot0
);
    assert_set_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_addr == 10'h010) |=> ((sc0 & $past(wdata)) == $past(wdata)));

    assert_alias_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_addr == 10'h011) |=> ((sc0 & $past(wdata)) == 32'h0));

    assert_strap_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_addr == 10'h140 && prot0 != 32'h0) |=> $stable(strap0));

    assert_strap_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_addr == 10'h141) |=> ((strap0 & $past(wdata)) == 32'h0));

    assert_pll_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_addr == 10'h081 || word_addr == 10'h089 || word_addr == 10'h091) |-> rdata[31]);

    assert_lock_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_addr != 10'h000 && !key_q) |=> lock_err);

    assert_lock_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |-> ($past(wr_en) && !$past(key_q)));

    assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_addr == 10'h3FF || word_addr == 10'h011) |-> (rdata == 32'h0));
endmodule

bind alias_regbank alias_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .word_addr (word_addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .lock_err  (lock_err),
    .key_q     (key_q),
    .sc0       (sc_q[0]),
    .strap0    (sc_q[4]),
    .prot0     (pl_q[5])
);

// File: tb/alias_regbank_bench.sv
`timescale 1ns/1ps
// Self-checking bench: full-window sweeps against a behavioural model of the bank.
module alias_regbank_bench;
    localparam logic [31:0] KEY = 32'hA5C3_0F1E;
    localparam logic [31:0] ID0 = 32'h1234ABCD;
    localparam logic [31:0] ID1 = 32'h88884444;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  word_addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] rev_in = 32'h0503_1A2B;
    logic [31:0] strap0_in = 32'h0000_C3A1;
    logic [31:0] strap1_in = 32'h8100_0042;
    logic        lock_err;

    int checks = 0;
    int failures = 0;
    logic [31:0] m [1024];
    logic km;

    always #2.5 clk = ~clk;

    alias_regbank u_alias_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_addr(word_addr), .wdata(wdata),
        .rdata(rdata), .rev_in(rev_in), .strap0_in(strap0_in), .strap1_in(strap1_in),
        .lock_err(lock_err)
    );

    function automatic bit is_set(int i);
        return i == 'h10 || i == 'h14 || i == 'h20 || i == 'h24 || i == 'h140 || i == 'h144;
    endfunction
    function automatic bit is_alias(int i);
        return i > 0 && is_set(i - 1);
    endfunction
    function automatic bit is_plain(int i);
        return i == 'h40 || i == 'h80 || i == 'h81 || i == 'h89 || i == 'h91 ||
               i == 'h142 || i == 'h146;
    endfunction
    function automatic bit is_pll(int i);
        return i == 'h81 || i == 'h89 || i == 'h91;
    endfunction
    function automatic bit is_ro(int i);
        return i == 1 || i == 5 || i == 'h150 || i == 'h16C || i == 'h16D;
    endfunction

    function automatic string req_of(int i);
        if (i == 0) return "R8";
        if (i == 'h140 || i == 'h144) return "R4";
        if (is_set(i)) return "R2";
        if (i == 'h141 || i == 'h145) return "R5";
        if (is_alias(i)) return "R3";
        if (is_pll(i)) return "R6";
        if (is_plain(i)) return "R11";
        if (is_ro(i)) return "R7";
        return "R10";
    endfunction

    function automatic logic [31:0] exp_rd(int i);
        if (i == 0) return {31'b0, km};
        if (is_pll(i)) return m[i] | 32'h8000_0000;
        return m[i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) m[i] = 32'h0;
        m['h10] = 32'hF7C3FED8; m['h14] = 32'hFFFFFFFC;
        m['h20] = 32'hFFFF7F8A; m['h24] = 32'hFFF0FFF0;
        m['h40] = 32'h00000040; m['h80] = 32'h1000405F;
        m[1] = rev_in; m[5] = rev_in;
        m['h140] = strap0_in; m['h144] = strap1_in;
        m['h16C] = ID0; m['h16D] = ID1;
        km = 1'b0;
    endtask

    task automatic model_write(int i, logic [31:0] d);
        if (i == 0) km = (d == KEY);
        else if (i == 'h140 || i == 'h144) begin
            if (m[i + 2] == 32'h0) m[i] = m[i] | d;
        end
        else if (is_set(i)) m[i] = m[i] | d;
        else if (is_alias(i)) m[i - 1] = m[i - 1] & ~d;
        else if (is_plain(i)) m[i] = d;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic rd_check(int i, string req);
        @(negedge clk);
        word_addr = 10'(i);
        #1;
        chk(req, rdata, exp_rd(i));
    endtask

    // Write, then check the R9 flag in the cycle after the write edge.
    task automatic do_write(int i, logic [31:0] d);
        bit exp_lock;
        exp_lock = (km == 1'b0) && (i != 0);
        @(negedge clk);
        wr_en = 1'b1; word_addr = 10'(i); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(i, d);
        chk("R9", {31'b0, lock_err}, {31'b0, exp_lock});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    function automatic logic [31:0] pat(int r, int i);
        case (r)
            0: return (32'(i) * 32'h9E3779B9) ^ 32'h0F0F0F0F;
            1: return ~(32'(i) * 32'h85EBCA6B);
            default: return (32'h1 << (i % 32)) | (32'h1 << ((i * 7) % 32));
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state over the whole window, lock flag idle.
        chk("R9", {31'b0, lock_err}, 32'h0);
        for (int i = 0; i < 1024; i++) rd_check(i, "R1");

        // R9: write while locked flags for one cycle and still lands.
        do_write('h40, 32'h0000_1234);
        rd_check('h40, "R9");
        chk("R9", {31'b0, lock_err}, 32'h0);

        // R8: wrong key leaves locked, correct key unlocks.
        do_write(0, 32'hDEAD_BEEF);
        rd_check(0, "R8");
        do_write(0, KEY);
        rd_check(0, "R8");

        // R4/R5: strap gating both ways, alias ignoring protect.
        do_write('h142, 32'h0000_0001);
        do_write('h140, 32'h0F00_00F0);
        rd_check('h140, "R4");
        do_write('h141, 32'hFFFF_FFFF);
        rd_check('h140, "R5");
        do_write('h142, 32'h0);
        do_write('h140, 32'h0000_00A5);
        rd_check('h140, "R4");
        // R6: stored zero still reads with bit 31 set.
        do_write('h89, 32'h0);
        rd_check('h89, "R6");

        // Full-window write sweeps: unlocked, locked, unlocked again.
        for (int r = 0; r < 3; r++) begin
            if (r == 1) do_write(0, 32'h0);
            if (r == 2) begin
                do_write(0, KEY);
                do_write('h142, 32'h0);
                do_write('h146, 32'h0);
            end
            for (int i = 1; i < 1024; i++) begin
                do_write(i, pat(r, i));
                rd_check(i, req_of(i));
                if (is_alias(i)) rd_check(i - 1, req_of(i));
            end
        end
        for (int i = 0; i < 1024; i++) rd_check(i, req_of(i));

        // R1: second reset with different inputs.
        rev_in = 32'h0600_0F03; strap0_in = 32'hFFFF_0000; strap1_in = 32'h0000_0001;
        do_reset();
        for (int i = 0; i < 1024; i++) rd_check(i, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule